// File: doc/BRIEF.md
# Programmable Color Lookup Table

This block turns the value read from the frame buffer bit planes into a drive value for the display. It holds a 256-entry palette of 12-bit words. Every clock, the pixel index on the input is looked up and the entry appears on the outputs one cycle later. A separate load port writes any single entry.

A mode input chooses how the entry is read. In color mode the word is split into three 4-bit intensities for blue, green and red. In monochrome mode the whole word is one 12-bit gray level. A plane-depth input gives the number of bit planes fitted (2, 4, 6 or 8). It masks the index so that only the reachable part of the palette is used.

Reset loads a fixed default palette. Black sits at entry 0 and a short gray ramp follows it. The last reachable entry for every plane depth is white. Every other entry holds a nonzero value, so a pixel that lands on an unloaded entry still shows something.

Top module: `pixel_palette`

## Requirements
- R1: The palette has 256 entries of 12 bits. When `loadEn` is high at a rising clock edge, `loadData` is written to the entry selected by all 8 bits of `loadAddr`. The load address is never masked by the plane depth.
- R2: The lookup is registered. The index, plane depth and mode present at a rising edge decide the outputs that hold from just after that edge until the next one.
- R3: In color mode (`monoMode` = 0), `outBlue` is entry bits 11:8, `outGreen` is bits 7:4 and `outRed` is bits 3:0. `outGray` reads zero in this mode.
- R4: In monochrome mode (`monoMode` = 1), `outGray` carries all 12 bits of the entry. `outBlue`, `outGreen` and `outRed` read zero in this mode.
- R5: `depthSel` codes 0, 1, 2 and 3 select 2, 4, 6 and 8 planes. Index bits at or above the plane count are forced to zero before the lookup, so indices that differ only in those bits give the same output.
- R6: After reset, entry 0 holds 0x000 and entry 7 holds 0xFFF. Entries 1 to 6 hold 0x444, 0x888, 0xFFF, 0xFFF, 0xFFF and 0xFFF, a gray ramp that never falls.
- R7: After reset, entries 3, 15, 63 and 255 hold 0xFFF. These are the last reachable entries for 2, 4, 6 and 8 planes.
- R8: After reset, every entry i not named in R6 or R7 holds {i[7:0], 4'h9}, which is never zero.
- R9: The reset contents are the same whichever mode is selected. Reading an entry in either mode shows the same 12-bit word.
- R10: When an entry is loaded and looked up at the same edge, the lookup returns the old contents. The new contents are returned from the next lookup onward.
- R11: While reset is asserted, all outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| loadEn | input | 1 | Write strobe for the palette |
| loadAddr | input | 8 | Entry to write |
| loadData | input | 12 | Word to write |
| pixIndex | input | 8 | Pixel value from the bit planes |
| depthSel | input | 2 | Plane depth: 0=2, 1=4, 2=6, 3=8 planes |
| monoMode | input | 1 | 1 selects the monochrome gray output |
| outBlue | output | 4 | Blue intensity (color mode) |
| outGreen | output | 4 | Green intensity (color mode) |
| outRed | output | 4 | Red intensity (color mode) |
| outGray | output | 12 | Gray level (monochrome mode) |

## Verification
The assertions check three things on every cycle. The unused output group is zero in each mode. The outputs are never unknown after reset. Two back-to-back lookups whose masked indices match, with no load in between, give the same output, which shows the index masking at work. The bench scenarios cover the rest. They check the exact default contents after reset and that those contents match in both modes. They check write-then-read ordering when a load and a lookup hit the same entry at the same edge. They check that a load lands on an address above the masked range, and they compare every random lookup against a reference model of the whole palette.

// File: rtl/palette_pkg.sv
package palette_pkg;
  localparam int IDX_W   = 8;
  localparam int CHAN_W  = 4;
  localparam int N_CHAN  = 3;
  localparam int ENTRY_W = CHAN_W * N_CHAN;
  localparam int DEPTH   = 1 << IDX_W;
  localparam int DSEL_W  = $clog2(IDX_W / 2);

  typedef struct packed {
    logic               wrEn;
    logic [IDX_W-1:0]   wrAddr;
    logic [ENTRY_W-1:0] wrData;
    logic [IDX_W-1:0]   rdAddr;
    logic               mono;
  } strobes_t;

  // Reset value of palette entry i.
  function automatic logic [ENTRY_W-1:0] defaultEntry(input int unsigned i);
    logic [IDX_W-1:0] iv;
    logic [ENTRY_W-1:0] v;
    iv = IDX_W'(i);
    v = {iv, 4'h9};
    if (i == 0) v = '0;
    else if (i == 1) v = 12'h444;
    else if (i == 2) v = 12'h888;
    else if (i >= 3 && i <= 7) v = '1;
    for (int k = 1; k <= IDX_W / 2; k++) begin
      if (i == (32'd1 << (2 * k)) - 1) v = '1;
    end
    return v;
  endfunction
endpackage

// File: rtl/palette_ctrl.sv
module palette_ctrl
  import palette_pkg::*;
(
  input  logic               loadEn,
  input  logic [IDX_W-1:0]   loadAddr,
  input  logic [ENTRY_W-1:0] loadData,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic [DSEL_W-1:0]  depthSel,
  input  logic               monoMode,
  output strobes_t           stb
);
  logic [IDX_W-1:0] keepMask;
  logic [IDX_W:0]   planeCount;

  assign planeCount = (IDX_W + 1)'(2 * (int'(depthSel) + 1));

  // One mask bit per index bit: kept only below the plane count.
  for (genvar b = 0; b < IDX_W; b++) begin : g_mask
    assign keepMask[b] = ((IDX_W + 1)'(b) < planeCount);
  end

  always_comb begin
    stb.wrEn   = loadEn;
    stb.wrAddr = loadAddr;
    stb.wrData = loadData;
    stb.rdAddr = pixIndex & keepMask;
    stb.mono   = monoMode;
  end
endmodule

// File: rtl/palette_data.sv
module palette_data
  import palette_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          stb,
  output logic [CHAN_W-1:0] outBlue,
  output logic [CHAN_W-1:0] outGreen,
  output logic [CHAN_W-1:0] outRed,
  output logic [ENTRY_W-1:0] outGray
);
  logic [ENTRY_W-1:0] table_q [DEPTH];
  logic [ENTRY_W-1:0] readQ;
  logic               monoQ;
  logic [CHAN_W-1:0]  chan [N_CHAN];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) table_q[e] <= defaultEntry(e);
    end else if (stb.wrEn) begin
      table_q[stb.wrAddr] <= stb.wrData;
    end
  end

  // Read samples the table before this edge's write: old data on collision.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readQ <= '0;
      monoQ <= 1'b0;
    end else begin
      readQ <= table_q[stb.rdAddr];
      monoQ <= stb.mono;
    end
  end

  // Channel 0 = low nibble (red), channel N_CHAN-1 = high nibble (blue).
  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    assign chan[c] = monoQ ? '0 : readQ[c*CHAN_W +: CHAN_W];
  end

  assign outRed   = chan[0];
  assign outGreen = chan[1];
  assign outBlue  = chan[2];
  assign outGray  = monoQ ? readQ : '0;
endmodule

// File: rtl/pixel_palette.sv
module pixel_palette
  import palette_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [IDX_W-1:0]   loadAddr,
  input  logic [ENTRY_W-1:0] loadData,
  input  logic [IDX_W-1:0]   pixIndex,
  input  logic [DSEL_W-1:0]  depthSel,
  input  logic               monoMode,
  output logic [CHAN_W-1:0]  outBlue,
  output logic [CHAN_W-1:0]  outGreen,
  output logic [CHAN_W-1:0]  outRed,
  output logic [ENTRY_W-1:0] outGray
);
  strobes_t stb;

  palette_ctrl u_ctrl (
    .loadEn  (loadEn),
    .loadAddr(loadAddr),
    .loadData(loadData),
    .pixIndex(pixIndex),
    .depthSel(depthSel),
    .monoMode(monoMode),
    .stb     (stb)
  );

  palette_data u_data (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .outBlue (outBlue),
    .outGreen(outGreen),
    .outRed  (outRed),
    .outGray (outGray)
  );
endmodule

// File: rtl/palette_checker.sv
module palette_checker
  import palette_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               loadEn,
  input logic [IDX_W-1:0]   pixIndex,
  input logic [DSEL_W-1:0]  depthSel,
  input logic               monoMode,
  input logic [CHAN_W-1:0]  outBlue,
  input logic [CHAN_W-1:0]  outGreen,
  input logic [CHAN_W-1:0]  outRed,
  input logic [ENTRY_W-1:0] outGray
);
  logic [1:0]       warm;
  logic [IDX_W-1:0] maskedIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  always_comb begin
    maskedIdx = '0;
    for (int b = 0; b < IDX_W; b++)
      if (b < 2 * (int'(depthSel) + 1)) maskedIdx[b] = pixIndex[b];
  end

  assert_mono_rgb_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && $past(monoMode)) |-> (outBlue == '0 && outGreen == '0 && outRed == '0));

  assert_color_gray_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && !$past(monoMode)) |-> (outGray == '0));

  assert_mask_alias_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd3 && $past(maskedIdx) == $past(maskedIdx, 2) &&
     $past(monoMode) == $past(monoMode, 2) && !$past(loadEn, 2))
    |-> ($stable(outGray) && $stable(outBlue) && $stable(outGreen) && $stable(outRed)));

  assert_known_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown({outBlue, outGreen, outRed, outGray}));
endmodule

bind pixel_palette palette_checker u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .loadEn  (loadEn),
  .pixIndex(pixIndex),
  .depthSel(depthSel),
  .monoMode(monoMode),
  .outBlue (outBlue),
  .outGreen(outGreen),
  .outRed  (outRed),
  .outGray (outGray)
);

// File: tb/sim_pixel_palette.sv
module sim_pixel_palette;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadEn = 1'b0;
  logic [7:0]  loadAddr = '0;
  logic [11:0] loadData = '0;
  logic [7:0]  pixIndex = '0;
  logic [1:0]  depthSel = 2'd3;
  logic        monoMode = 1'b0;
  logic [3:0]  outBlue, outGreen, outRed;
  logic [11:0] outGray;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [11:0] model [256];

  always #5 clk = ~clk;

  pixel_palette u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadAddr(loadAddr),
    .loadData(loadData), .pixIndex(pixIndex), .depthSel(depthSel),
    .monoMode(monoMode), .outBlue(outBlue), .outGreen(outGreen),
    .outRed(outRed), .outGray(outGray)
  );

  function automatic logic [11:0] resetValue(input int i);
    if (i == 0) return 12'h000;
    if (i == 1) return 12'h444;
    if (i == 2) return 12'h888;
    if ((i >= 3 && i <= 7) || i == 15 || i == 63 || i == 255) return 12'hFFF;
    return {i[7:0], 4'h9};
  endfunction

  function automatic logic [7:0] maskIdx(input logic [7:0] idx, input logic [1:0] d);
    int planes = 2 * (int'(d) + 1);
    logic [7:0] m = 8'((16'd1 << planes) - 1);
    return idx & m;
  endfunction

  task automatic expectOut(input logic [11:0] word, input logic mono, input string req);
    logic [23:0] exp, act;
    exp = mono ? {12'h000, word} : {word[11:8], word[7:4], word[3:0], 12'h000};
    act = {outBlue, outGreen, outRed, outGray};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got bgr/gray %h expected %h", req, act, exp);
    end
  endtask

  // Drives one cycle at the falling edge, checks just after the rising edge.
  task automatic step(input logic [7:0] idx, input logic [1:0] d, input logic mono,
                      input logic we, input logic [7:0] wa, input logic [11:0] wd,
                      input string req, input bit doCheck);
    logic [11:0] expWord;
    @(negedge clk);
    pixIndex = idx; depthSel = d; monoMode = mono;
    loadEn = we; loadAddr = wa; loadData = wd;
    expWord = model[maskIdx(idx, d)];
    if (we) model[wa] = wd;
    @(posedge clk); #1;
    if (doCheck) expectOut(expWord, mono, req);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) model[i] = resetValue(i);
    repeat (3) @(posedge clk);
    #1;
    checks++;   // R11: outputs zero during reset
    if ({outBlue, outGreen, outRed, outGray} !== 24'h0) begin
      errors++;
      $display("FAIL R11: got %h expected 0", {outBlue, outGreen, outRed, outGray});
    end
    @(negedge clk); rstN = 1'b1;

    // R6 R7 R8 R3: defaults in color mode at full depth
    for (int i = 0; i < 8; i++) step(8'(i), 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R6", 1);
    step(8'd15, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R7", 1);
    step(8'd63, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R7", 1);
    step(8'd255, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R7", 1);
    step(8'd100, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R8", 1);
    step(8'd200, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R8", 1);
    // R9 R4: same contents in monochrome mode
    step(8'd100, 2'd3, 1'b1, 1'b0, 8'h0, 12'h0, "R9", 1);
    step(8'd2,   2'd3, 1'b1, 1'b0, 8'h0, 12'h0, "R4", 1);
    step(8'd255, 2'd3, 1'b1, 1'b0, 8'h0, 12'h0, "R9", 1);
    // R5: upper index bits dropped per depth
    step(8'hFF, 2'd0, 1'b0, 1'b0, 8'h0, 12'h0, "R5", 1);
    step(8'hFF, 2'd1, 1'b1, 1'b0, 8'h0, 12'h0, "R5", 1);
    step(8'hFF, 2'd2, 1'b0, 1'b0, 8'h0, 12'h0, "R5", 1);
    step(8'hC9, 2'd2, 1'b1, 1'b0, 8'h0, 12'h0, "R5", 1);
    // R1: load above masked range lands unmasked
    step(8'h00, 2'd0, 1'b0, 1'b1, 8'd200, 12'h5A3, "R1", 1);
    step(8'd200, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R1", 1);
    // R10: collision returns old, then new
    step(8'd10, 2'd3, 1'b0, 1'b1, 8'd10, 12'h123, "R10", 1);
    step(8'd10, 2'd3, 1'b0, 1'b0, 8'h0, 12'h0, "R10", 1);
    // R2: latency, index changed right after the sampled edge
    step(8'd7, 2'd3, 1'b1, 1'b0, 8'h0, 12'h0, "R2", 0);
    @(negedge clk); pixIndex = 8'd0; #1;
    expectOut(12'hFFF, 1'b1, "R2");

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      logic we;
      logic [7:0] wa, idx;
      we  = ($urandom % 4) == 0;
      wa  = 8'($urandom);
      idx = ((n % 7) == 0 && we) ? wa : 8'($urandom);
      step(idx, 2'($urandom), 1'($urandom), we, wa, 12'($urandom), "R1/R3/R4/R5/R10", 1);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule